// File: doc/BRIEF.md
# Control-Gated Pulse-Width Modulator

This block produces one pulse-width-modulated output from a free-running counter. A counter steps from zero up to a programmed terminal value and then returns to zero, so one output cycle lasts terminal+1 clocks. Each clock, the counter is compared against a programmed threshold, and the registered result drives the output. A register stage therefore sits between the compare logic and the pin, so the output changes only on clock edges and carries no combinational glitches.

A processor sets up three registers through a simple write port: an 8-bit control word, the threshold and the terminal value. Bit 0 of the control word starts and stops the counter. The counter's next action comes from a 3-bit configuration code. The top bit is always 0, the middle bit is the enable bit and the low bit is the terminal-count match. From that code the counter either holds, steps up or returns to zero. The whole control word can be read back at any time.

Top module: `ctl_pwm`

## Requirements
- R1: While `rst_n` is low, the counter, the control word, the threshold, the terminal value and `pwm` are all cleared. After release, `pwm` is 0 and `ctrl_rd` is 0.
- R2: A write with `wr_en` high loads `wr_data` on the next clock edge. The target depends on `wr_sel`: 0 selects the control word, 1 the threshold, 2 the terminal value. Code 3 changes nothing. `ctrl_rd` always returns all 8 bits of the control word.
- R3: While control bit 0 is 1 and the counter is not equal to the terminal value (configuration code 010), the counter steps up by one each clock.
- R4: While control bit 0 is 1 and the counter equals the terminal value (code 011), the counter returns to 0. The output repeats every terminal+1 clocks.
- R5: While control bit 0 is 0 (codes 000 and 001), the counter and `pwm` keep their values. This holds even when the threshold or the terminal value is rewritten.
- R6: While enabled, `pwm` after a clock edge equals (counter < threshold) as it stood before that edge. The output is therefore one clock behind the compare.
- R7: A threshold of 0 keeps `pwm` at 0 for the whole cycle.
- R8: A threshold greater than the terminal value keeps `pwm` at 1 for the whole cycle.
- R9: Once settled, `pwm` is high for min(threshold, terminal+1) clocks in every cycle.
- R10: Control bits 7 to 1 have no effect on counting or on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 threshold, 2 terminal value, 3 none |
| wr_data | input | BUS_W (8) | Write data; threshold and terminal take the low WIDTH bits |
| ctrl_rd | output | CTRL_W (8) | Read-back of the control word |
| pwm | output | 1 | Registered PWM output |

## Verification
The bench builds the block with a 4-bit counter and keeps the 8-bit control word and write bus. This makes every pairing of threshold and terminal value, 256 in all, reachable within a short run. For each pairing, the bench follows the output clock by clock against an arithmetic model. It also counts high clocks over one settled cycle and measures the spacing between rising edges. Both extreme thresholds, a terminal value of 0 and a counter that wraps past a newly lowered terminal value all come up within this sweep.

// File: rtl/ctl_pwm_pkg.sv
package ctl_pwm_pkg;

  // Counter action code: {1'b0, enable, terminal match}
  typedef enum logic [2:0] {
    ACT_IDLE_A = 3'b000,
    ACT_IDLE_B = 3'b001,
    ACT_STEP   = 3'b010,
    ACT_WRAP   = 3'b011
  } cnt_act_e;

  // Write target select
  typedef enum logic [1:0] {
    TGT_CTRL   = 2'd0,
    TGT_THRESH = 2'd1,
    TGT_TERM   = 2'd2,
    TGT_NONE   = 2'd3
  } wr_tgt_e;

endpackage

// File: rtl/ctl_pwm_regs.sv
module ctl_pwm_regs
  import ctl_pwm_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int CTRL_W = 8,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [WIDTH-1:0]  thresh_q,
  output logic [WIDTH-1:0]  term_q
);

  localparam int NREG = 3;

  logic [NREG-1:0] ld;

  // one-hot load decode per target
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign ld[i] = wr_en && (wr_sel == 2'(i));
    end
  endgenerate

  logic [CTRL_W-1:0] ctrl_d;
  logic [WIDTH-1:0]  thresh_d;
  logic [WIDTH-1:0]  term_d;

  always_comb begin
    ctrl_d   = ld[TGT_CTRL]   ? wr_data[CTRL_W-1:0] : ctrl_q;
    thresh_d = ld[TGT_THRESH] ? wr_data[WIDTH-1:0]  : thresh_q;
    term_d   = ld[TGT_TERM]   ? wr_data[WIDTH-1:0]  : term_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      thresh_q <= '0;
      term_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      thresh_q <= thresh_d;
      term_q   <= term_d;
    end
  end

endmodule

// File: rtl/ctl_pwm_counter.sv
module ctl_pwm_counter
  import ctl_pwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIDTH-1:0] term,
  output logic [WIDTH-1:0] cnt_q
);

  logic             at_term;
  cnt_act_e         act;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_ce;

  assign at_term = (cnt_q == term);
  assign act     = cnt_act_e'({1'b0, run, at_term});

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    unique case (act)
      ACT_STEP: begin
        cnt_ce = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
      ACT_WRAP: begin
        cnt_ce = 1'b1;
        cnt_d  = '0;
      end
      default: begin
        cnt_ce = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ctl_pwm_out.sv
module ctl_pwm_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] thresh,
  output logic             pwm_q
);

  logic below;

  assign below = (cnt < thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (run) begin
      pwm_q <= below;
    end
  end

endmodule

// File: rtl/ctl_pwm.sv
module ctl_pwm
  import ctl_pwm_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int CTRL_W = 8,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              pwm
);

  localparam int RUN_BIT = 0;

  logic [CTRL_W-1:0] ctrl_q;
  logic [WIDTH-1:0]  thresh_q;
  logic [WIDTH-1:0]  term_q;
  logic [WIDTH-1:0]  cnt_q;
  logic              run;

  ctl_pwm_regs #(.WIDTH(WIDTH), .CTRL_W(CTRL_W), .BUS_W(BUS_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .thresh_q (thresh_q),
    .term_q   (term_q)
  );

  assign run = ctrl_q[RUN_BIT];

  ctl_pwm_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .term  (term_q),
    .cnt_q (cnt_q)
  );

  ctl_pwm_out #(.WIDTH(WIDTH)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .cnt    (cnt_q),
    .thresh (thresh_q),
    .pwm_q  (pwm)
  );

  assign ctrl_rd = ctrl_q;

endmodule

// File: rtl/ctl_pwm_chk.sv
module ctl_pwm_chk #(
  parameter int WIDTH  = 8,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [WIDTH-1:0]  cnt_q,
  input logic [WIDTH-1:0]  term_q,
  input logic [WIDTH-1:0]  thresh_q,
  input logic              pwm
);

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && cnt_q != term_q) |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1))); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && cnt_q == term_q) |=> (cnt_q == '0)); // R4

  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> $stable(cnt_q)); // R5

  AST_HOLD_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> $stable(pwm)); // R5

  AST_PWM_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |=> (pwm == ($past(cnt_q) < $past(thresh_q)))); // R6

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && thresh_q == '0) |=> !pwm); // R7

  AST_ABOVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && thresh_q > term_q && cnt_q <= term_q) |=> pwm); // R8

endmodule

bind ctl_pwm ctl_pwm_chk #(.WIDTH(WIDTH), .CTRL_W(CTRL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_q   (ctrl_q),
  .cnt_q    (cnt_q),
  .term_q   (term_q),
  .thresh_q (thresh_q),
  .pwm      (pwm)
);

// File: tb/ctl_pwm_test.sv
module ctl_pwm_test;

  localparam int W    = 4;
  localparam int CW   = 8;
  localparam int BW   = 8;
  localparam int MAXV = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [BW-1:0] wr_data;
  logic [CW-1:0] ctrl_rd;
  logic          pwm;

  int n_run  = 0;
  int n_fail = 0;
  int m_cnt, m_lim, m_per, m_ctrl, m_pwm;
  int trace_err;

  always #5 clk = ~clk;

  ctl_pwm #(.WIDTH(W), .CTRL_W(CW), .BUS_W(BW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctrl_rd (ctrl_rd),
    .pwm     (pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, advance one clock, compare at next fall.
  task automatic step(input bit we, input int sel, input int data);
    int n_cnt, n_pwm;
    wr_en   = we;
    wr_sel  = 2'(sel);
    wr_data = BW'(data);
    if (m_ctrl % 2 == 1) begin
      n_pwm = (m_cnt < m_lim) ? 1 : 0;
      n_cnt = (m_cnt == m_per) ? 0 : ((m_cnt + 1) & MAXV);
    end else begin
      n_pwm = m_pwm;
      n_cnt = m_cnt;
    end
    if (we) begin
      if (sel == 0) m_ctrl = data & 255;
      if (sel == 1) m_lim  = data & MAXV;
      if (sel == 2) m_per  = data & MAXV;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_cnt = n_cnt;
    m_pwm = n_pwm;
    if (int'(pwm) != m_pwm) trace_err++;
  endtask

  initial begin
    #1_500_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int highs, expect_hi, per_len, prev;
    bit found;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    m_cnt = 0; m_lim = 0; m_per = 0; m_ctrl = 0; m_pwm = 0; trace_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm after reset", int'(pwm), 0);
    chk("R1 ctrl after reset", int'(ctrl_rd), 0);

    // R2: full control readback; target 3 is ignored
    step(1, 0, 8'hA4);
    chk("R2 ctrl readback", int'(ctrl_rd), 8'hA4);
    step(1, 3, 8'hFF);
    chk("R2 target 3 ignored", int'(ctrl_rd), 8'hA4);
    step(1, 0, 0);

    for (int p = 0; p <= MAXV; p++) begin
      for (int l = 0; l <= MAXV; l++) begin
        trace_err = 0;
        // R10: upper control bits vary, bit 0 clear holds
        step(1, 0, ((p * 16 + l) << 1) & 8'hFE);
        step(1, 1, l);
        step(1, 2, p);
        step(1, 0, (((p * 16 + l) << 1) | 1) & 255);
        chk("R2 R10 ctrl readback", int'(ctrl_rd), (((p * 16 + l) << 1) | 1) & 255);
        repeat (MAXV + 2) step(0, 0, 0);
        highs = 0;
        for (int k = 0; k <= p; k++) begin
          step(0, 0, 0);
          highs += int'(pwm);
        end
        expect_hi = (l < p + 1) ? l : p + 1;
        chk("R9 high clocks per cycle", highs, expect_hi);
        if (l == 0) chk("R7 zero threshold stays low", highs, 0);
        if (l > p)  chk("R8 threshold above terminal stays high", highs, p + 1);
        if (l > 0 && l <= p) begin
          // R4: spacing between rising edges
          found = 0;
          prev = int'(pwm);
          for (int k = 0; k < 3 * (p + 1) && !found; k++) begin
            step(0, 0, 0);
            if (prev == 0 && pwm) found = 1;
            prev = int'(pwm);
          end
          per_len = 0;
          found = 0;
          for (int k = 0; k < 3 * (p + 1) && !found; k++) begin
            step(0, 0, 0);
            per_len++;
            if (prev == 0 && pwm) found = 1;
            prev = int'(pwm);
          end
          chk("R4 output repeat length", per_len, p + 1);
        end
        chk("R3 R6 clock-by-clock trace", trace_err, 0);
      end
    end

    // R5: hold while disabled, even across threshold and terminal writes
    trace_err = 0;
    step(1, 1, 5);
    step(1, 2, 9);
    step(1, 0, 1);
    repeat (7) step(0, 0, 0);
    step(1, 0, 8'h80);
    prev = int'(pwm);
    step(1, 1, 0);
    chk("R5 pwm held after threshold write", int'(pwm), prev);
    step(1, 1, MAXV);
    step(1, 2, 2);
    repeat (4) step(0, 0, 0);
    chk("R5 pwm held while disabled", int'(pwm), prev);
    step(1, 1, 5);
    step(1, 2, 9);
    step(1, 0, 1);
    repeat (25) step(0, 0, 0);
    chk("R5 counter resumes from held value", trace_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule